// File: doc/BRIEF.md
# Two-Way Debug Mailbox

This block moves single 32-bit words between an off-chip debug host and on-chip firmware. Two independent one-word channels are provided. On the outbound channel (host to device) the host produces and the firmware consumes. On the inbound channel (device to host) the firmware produces and the host consumes. Each channel holds one data word, a full/empty status bit and a 7-bit flag field that only its producer can change.

Each side reaches the mailbox through its own simple register port. A port access is a select, a write enable, a 3-bit word address and write data. Read data is returned combinationally in the same cycle. A read of a channel's data register by its consumer is destructive and empties the channel. Peek addresses show the same word with no side effect.

Two single-cycle event outputs let an interrupt controller wake the firmware when the outbound channel fills. They also let it notice when the inbound channel drains.

Top module: `dbg_mailbox`

## Requirements
- R1: The word address map, the same on both ports, is:
  - 0: outbound data
  - 1: outbound control
  - 2: inbound data
  - 3: inbound control
  - 4: outbound peek
  - 5: inbound peek
- R2: A host write to address 0 stores the word and sets the outbound status to full.
- R3: A device read of address 0 returns the stored word and sets the outbound status to empty. A host read of address 0 returns the word and leaves the status unchanged.
- R4: A producer write while its channel is full overwrites the word, and the channel stays full. A consumer read of an empty channel returns the stale word, and the channel stays empty.
- R5: If the producer writes a channel's data in the same cycle that the consumer reads it, the reader gets the old word, the new word is stored and the status ends full.
- R6: A device write to address 2 stores the word and sets the inbound status to full. A read of address 2 by either the host or the device sets it to empty.
- R7: A control word has the channel's full status in bit 0 and the 7-bit flags in bits 7..1. Only the producer can write the flags (host for address 1, device for address 3), taking them from write-data bits 7..1. Writes to bit 0, and control writes from the consuming side, are ignored.
- R8: The peek addresses return the channel's current data word and never change its status.
- R9: All data words, flags and status bits reset to 0 under the synchronous active-high reset.
- R10: `tx_evt` is high for exactly one cycle, the cycle after the edge at which the outbound status goes from empty to full. `rx_evt` is high for exactly one cycle, the cycle after the edge at which the inbound status goes from full to empty.
- R11: Bits 31..8 of control reads are 0. Addresses 6 and 7 read as 0, and writes to them are ignored. Writes to peek addresses are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| h_sel | input | 1 | Host access valid this cycle |
| h_wr | input | 1 | Host access is a write (1) or read (0) |
| h_addr | input | 3 | Host word address |
| h_wdata | input | 32 | Host write data |
| h_rdata | output | 32 | Host read data, same cycle, 0 when not reading |
| d_sel | input | 1 | Device access valid this cycle |
| d_wr | input | 1 | Device access is a write (1) or read (0) |
| d_addr | input | 3 | Device word address |
| d_wdata | input | 32 | Device write data |
| d_rdata | output | 32 | Device read data, same cycle, 0 when not reading |
| tx_evt | output | 1 | Pulse: outbound channel became full |
| rx_evt | output | 1 | Pulse: inbound channel became empty |

## Verification
The hardest case to reach is a collision: a producer write and a destructive consumer read of the same channel in the same cycle. Only this case decides between the old and the new word and fixes the final status. The bench drives both ports in one task call so that the two accesses land on the same edge, for both channels. It then reads the old word in that cycle, reads the control word, and reads the new word, and checks that no event pulse appeared. The stale-read and overwrite cases are reached by deliberately reading an emptied channel and writing a filled one.

// File: rtl/dbg_mbx_pkg.sv
package dbg_mbx_pkg;

    localparam int WORD_W = 32;
    localparam int FLAG_W = 7;
    localparam int ADDR_W = 3;
    localparam int PAD_W  = WORD_W - FLAG_W - 1;

    typedef enum logic [ADDR_W-1:0] {
        A_OUT_DATA = 3'd0,
        A_OUT_CTL  = 3'd1,
        A_IN_DATA  = 3'd2,
        A_IN_CTL   = 3'd3,
        A_OUT_PEEK = 3'd4,
        A_IN_PEEK  = 3'd5
    } mbx_addr_e;

    typedef struct packed {
        logic [WORD_W-1:0] data;
        logic [FLAG_W-1:0] flags;
        logic              full;
    } chan_state_t;

    typedef struct packed {
        logic              put;
        logic              set_flags;
        logic              take;
        logic [WORD_W-1:0] wdata;
    } chan_cmd_t;

    function automatic logic [WORD_W-1:0] ctl_word(input chan_state_t s);
        return {{PAD_W{1'b0}}, s.flags, s.full};
    endfunction

    function automatic logic [WORD_W-1:0] read_mux(input logic [ADDR_W-1:0] a,
                                                   input chan_state_t out_s,
                                                   input chan_state_t in_s);
        logic [WORD_W-1:0] r;
        case (a)
            A_OUT_DATA, A_OUT_PEEK: r = out_s.data;
            A_OUT_CTL:              r = ctl_word(out_s);
            A_IN_DATA,  A_IN_PEEK:  r = in_s.data;
            A_IN_CTL:               r = ctl_word(in_s);
            default:                r = '0;
        endcase
        return r;
    endfunction

    function automatic chan_cmd_t merge_cmd(input chan_cmd_t a, input chan_cmd_t b);
        chan_cmd_t m;
        m.put       = a.put | b.put;
        m.set_flags = a.set_flags | b.set_flags;
        m.take      = a.take | b.take;
        m.wdata     = (a.put | a.set_flags) ? a.wdata : b.wdata;
        return m;
    endfunction

endpackage

// File: rtl/mbx_chan.sv
module mbx_chan
    import dbg_mbx_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  chan_cmd_t   cmd,
    output chan_state_t st,
    output logic        fill_evt,
    output logic        drain_evt
);

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= '0;
            fill_evt  <= 1'b0;
            drain_evt <= 1'b0;
        end else begin
            if (cmd.put) begin
                st.data <= cmd.wdata;
            end
            if (cmd.set_flags) begin
                st.flags <= cmd.wdata[FLAG_W:1];
            end
            if (cmd.put) begin
                st.full <= 1'b1;
            end else if (cmd.take) begin
                st.full <= 1'b0;
            end
            fill_evt  <= cmd.put && !st.full;
            drain_evt <= cmd.take && !cmd.put && st.full;
        end
    end

endmodule

// File: rtl/mbx_side.sv
module mbx_side
    import dbg_mbx_pkg::*;
#(
    parameter bit IS_HOST = 1'b1
) (
    input  logic              sel,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] wdata,
    input  chan_state_t       out_s,
    input  chan_state_t       in_s,
    output chan_cmd_t         out_cmd,
    output chan_cmd_t         in_cmd,
    output logic [WORD_W-1:0] rdata
);

    logic rd_s;
    logic wr_s;

    assign rd_s = sel && !wr;
    assign wr_s = sel && wr;

    assign rdata = rd_s ? read_mux(addr, out_s, in_s) : '0;

    generate
        if (IS_HOST) begin : g_host
            always_comb begin
                out_cmd           = '0;
                out_cmd.put       = wr_s && (addr == A_OUT_DATA);
                out_cmd.set_flags = wr_s && (addr == A_OUT_CTL);
                out_cmd.wdata     = wdata;
                in_cmd            = '0;
                in_cmd.take       = rd_s && (addr == A_IN_DATA);
                in_cmd.wdata      = wdata;
            end
        end else begin : g_dev
            always_comb begin
                out_cmd           = '0;
                out_cmd.take      = rd_s && (addr == A_OUT_DATA);
                out_cmd.wdata     = wdata;
                in_cmd            = '0;
                in_cmd.put        = wr_s && (addr == A_IN_DATA);
                in_cmd.set_flags  = wr_s && (addr == A_IN_CTL);
                in_cmd.take       = rd_s && (addr == A_IN_DATA);
                in_cmd.wdata      = wdata;
            end
        end
    endgenerate

endmodule

// File: rtl/dbg_mailbox.sv
module dbg_mailbox
    import dbg_mbx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              h_sel,
    input  logic              h_wr,
    input  logic [ADDR_W-1:0] h_addr,
    input  logic [WORD_W-1:0] h_wdata,
    output logic [WORD_W-1:0] h_rdata,
    input  logic              d_sel,
    input  logic              d_wr,
    input  logic [ADDR_W-1:0] d_addr,
    input  logic [WORD_W-1:0] d_wdata,
    output logic [WORD_W-1:0] d_rdata,
    output logic              tx_evt,
    output logic              rx_evt
);

    chan_state_t out_st;
    chan_state_t in_st;
    chan_cmd_t   h_out_cmd, h_in_cmd;
    chan_cmd_t   d_out_cmd, d_in_cmd;
    chan_cmd_t   out_cmd,   in_cmd;
    logic        out_full;
    logic        in_full;

    mbx_side #(.IS_HOST(1'b1)) u_host (
        .sel(h_sel), .wr(h_wr), .addr(h_addr), .wdata(h_wdata),
        .out_s(out_st), .in_s(in_st),
        .out_cmd(h_out_cmd), .in_cmd(h_in_cmd), .rdata(h_rdata)
    );

    mbx_side #(.IS_HOST(1'b0)) u_dev (
        .sel(d_sel), .wr(d_wr), .addr(d_addr), .wdata(d_wdata),
        .out_s(out_st), .in_s(in_st),
        .out_cmd(d_out_cmd), .in_cmd(d_in_cmd), .rdata(d_rdata)
    );

    assign out_cmd = merge_cmd(h_out_cmd, d_out_cmd);
    assign in_cmd  = merge_cmd(d_in_cmd, h_in_cmd);

    mbx_chan u_out (
        .clk(clk), .rst(rst), .cmd(out_cmd), .st(out_st),
        .fill_evt(tx_evt), .drain_evt()
    );

    mbx_chan u_in (
        .clk(clk), .rst(rst), .cmd(in_cmd), .st(in_st),
        .fill_evt(), .drain_evt(rx_evt)
    );

    assign out_full = out_st.full;
    assign in_full  = in_st.full;

endmodule

// File: rtl/mbx_checker.sv
module mbx_checker (
    input logic        clk,
    input logic        rst,
    input logic        h_sel,
    input logic        h_wr,
    input logic [2:0]  h_addr,
    input logic        d_sel,
    input logic        d_wr,
    input logic [2:0]  d_addr,
    input logic [31:0] h_rdata,
    input logic [31:0] d_rdata,
    input logic        tx_evt,
    input logic        rx_evt,
    input logic        out_full,
    input logic        in_full
);

    logic h_put_out, d_take_out, h_rd_out, d_put_in, any_take_in, h_ctl_rd, d_ctl_rd;

    assign h_put_out   = h_sel && h_wr && (h_addr == 3'd0);
    assign d_take_out  = d_sel && !d_wr && (d_addr == 3'd0);
    assign h_rd_out    = h_sel && !h_wr && (h_addr == 3'd0);
    assign d_put_in    = d_sel && d_wr && (d_addr == 3'd2);
    assign any_take_in = (h_sel && !h_wr && (h_addr == 3'd2)) || (d_sel && !d_wr && (d_addr == 3'd2));
    assign h_ctl_rd    = h_sel && !h_wr && (h_addr == 3'd1 || h_addr == 3'd3);
    assign d_ctl_rd    = d_sel && !d_wr && (d_addr == 3'd1 || d_addr == 3'd3);

    a_r2_fill: assert property (@(posedge clk) disable iff (rst)
        h_put_out |=> out_full);

    a_r3_take: assert property (@(posedge clk) disable iff (rst)
        (d_take_out && !h_put_out) |=> !out_full);

    a_r3_host_read_keeps: assert property (@(posedge clk) disable iff (rst)
        (h_rd_out && !d_take_out) |=> (out_full == $past(out_full)));

    a_r5_collide_full: assert property (@(posedge clk) disable iff (rst)
        (d_put_in && any_take_in) |=> in_full);

    a_r6_drain: assert property (@(posedge clk) disable iff (rst)
        (any_take_in && !d_put_in) |=> !in_full);

    a_r10_tx_pulse: assert property (@(posedge clk) disable iff (rst)
        tx_evt |-> (out_full && !$past(out_full)));

    a_r10_rx_pulse: assert property (@(posedge clk) disable iff (rst)
        rx_evt |-> (!in_full && $past(in_full)));

    a_r11_ctl_pad: assert property (@(posedge clk) disable iff (rst)
        (h_ctl_rd || d_ctl_rd) |-> ((h_rdata[31:8] | d_rdata[31:8]) == 24'd0));

endmodule

bind dbg_mailbox mbx_checker u_chk (
    .clk(clk), .rst(rst),
    .h_sel(h_sel), .h_wr(h_wr), .h_addr(h_addr),
    .d_sel(d_sel), .d_wr(d_wr), .d_addr(d_addr),
    .h_rdata(h_rdata), .d_rdata(d_rdata),
    .tx_evt(tx_evt), .rx_evt(rx_evt),
    .out_full(out_full), .in_full(in_full)
);

// File: tb/sim_dbg_mailbox.sv
`timescale 1ns/1ps
module sim_dbg_mailbox;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        h_sel = 1'b0, h_wr = 1'b0, d_sel = 1'b0, d_wr = 1'b0;
    logic [2:0]  h_addr = '0, d_addr = '0;
    logic [31:0] h_wdata = '0, d_wdata = '0;
    logic [31:0] h_rdata, d_rdata;
    logic        tx_evt, rx_evt;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    typedef struct {
        bit          dev_side;
        logic [31:0] exp;
        string       tag;
    } sb_item_t;

    sb_item_t sb[$];

    always #4 clk = ~clk;

    dbg_mailbox u0 (
        .clk(clk), .rst(rst),
        .h_sel(h_sel), .h_wr(h_wr), .h_addr(h_addr), .h_wdata(h_wdata), .h_rdata(h_rdata),
        .d_sel(d_sel), .d_wr(d_wr), .d_addr(d_addr), .d_wdata(d_wdata), .d_rdata(d_rdata),
        .tx_evt(tx_evt), .rx_evt(rx_evt)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: samples read data 2 ns after the driving edge
    initial begin
        forever begin
            @(negedge clk);
            #2;
            while (sb.size() > 0) begin
                sb_item_t it;
                it = sb.pop_front();
                chk(it.tag, it.dev_side ? d_rdata : h_rdata, it.exp);
            end
        end
    end

    task automatic exp_h(input logic [31:0] v, input string tag);
        sb.push_back('{1'b0, v, tag});
    endtask

    task automatic exp_d(input logic [31:0] v, input string tag);
        sb.push_back('{1'b1, v, tag});
    endtask

    task automatic cyc(input bit hs, input bit hw, input logic [2:0] ha, input logic [31:0] hd,
                       input bit ds, input bit dw, input logic [2:0] da, input logic [31:0] dd);
        @(negedge clk);
        h_sel = hs; h_wr = hw; h_addr = ha; h_wdata = hd;
        d_sel = ds; d_wr = dw; d_addr = da; d_wdata = dd;
        @(posedge clk);
        #1;
        h_sel = 1'b0; h_wr = 1'b0; d_sel = 1'b0; d_wr = 1'b0;
    endtask

    task automatic hw_(input logic [2:0] a, input logic [31:0] v);
        cyc(1, 1, a, v, 0, 0, 0, 0);
    endtask
    task automatic hr_(input logic [2:0] a, input logic [31:0] e, input string tag);
        exp_h(e, tag);
        cyc(1, 0, a, 0, 0, 0, 0, 0);
    endtask
    task automatic dw_(input logic [2:0] a, input logic [31:0] v);
        cyc(0, 0, 0, 0, 1, 1, a, v);
    endtask
    task automatic dr_(input logic [2:0] a, input logic [31:0] e, input string tag);
        exp_d(e, tag);
        cyc(0, 0, 0, 0, 1, 0, a, 0);
    endtask
    task automatic idle();
        cyc(0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL R9 watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R9 reset values
        hr_(3'd0, 32'h0, "R9 out data reset");
        hr_(3'd1, 32'h0, "R9 out ctl reset");
        dr_(3'd2, 32'h0, "R9 in data reset");
        dr_(3'd3, 32'h0, "R9 in ctl reset");
        chk("R9 tx_evt reset", {31'd0, tx_evt}, 32'd0);

        // R2 host write fills, R10 tx pulse
        hw_(3'd0, 32'hA1B2C3D4);
        chk("R10 tx_evt on fill", {31'd0, tx_evt}, 32'd1);
        hr_(3'd1, 32'h1, "R2 out full");
        chk("R10 tx_evt single cycle", {31'd0, tx_evt}, 32'd0);
        hr_(3'd0, 32'hA1B2C3D4, "R3 host read word");
        hr_(3'd1, 32'h1, "R3 host read keeps full");

        // R8 peek
        dr_(3'd4, 32'hA1B2C3D4, "R8 device peek out");
        dr_(3'd1, 32'h1, "R8 peek keeps full");

        // R4 overwrite while full
        hw_(3'd0, 32'h11110000);
        chk("R4 no tx_evt when already full", {31'd0, tx_evt}, 32'd0);
        dr_(3'd0, 32'h11110000, "R3 device read gets new word");
        dr_(3'd1, 32'h0, "R3 device read empties");
        dr_(3'd0, 32'h11110000, "R4 stale read");
        dr_(3'd1, 32'h0, "R4 stale read stays empty");

        // R7 outbound flags
        hw_(3'd1, 32'hFFFFFF55);
        hr_(3'd1, 32'h54, "R7 host flags, bit0 ignored");
        dw_(3'd1, 32'h0);
        hr_(3'd1, 32'h54, "R7 device write to out ctl ignored");

        // R5 collision on outbound
        hw_(3'd0, 32'h22222222);
        exp_d(32'h22222222, "R5 reader gets old word");
        cyc(1, 1, 3'd0, 32'h33333333, 1, 0, 3'd0, 0);
        chk("R5 no tx_evt on collision", {31'd0, tx_evt}, 32'd0);
        dr_(3'd1, 32'h55, "R5 status ends full");
        dr_(3'd0, 32'h33333333, "R5 new word stored");
        dr_(3'd1, 32'h54, "R5 drained after read");

        // R6 inbound, host drains, R10 rx pulse
        dw_(3'd2, 32'hDEADBEEF);
        hr_(3'd3, 32'h1, "R6 in full");
        hr_(3'd2, 32'hDEADBEEF, "R6 host read word");
        chk("R10 rx_evt on drain", {31'd0, rx_evt}, 32'd1);
        hr_(3'd3, 32'h0, "R6 host read empties");
        chk("R10 rx_evt single cycle", {31'd0, rx_evt}, 32'd0);

        // R6 device flush
        dw_(3'd2, 32'hCAFEF00D);
        dr_(3'd2, 32'hCAFEF00D, "R6 device flush read");
        chk("R10 rx_evt on flush", {31'd0, rx_evt}, 32'd1);
        dr_(3'd3, 32'h0, "R6 flush empties");
        hr_(3'd5, 32'hCAFEF00D, "R8 host peek in");
        hr_(3'd3, 32'h0, "R8 peek leaves empty");

        // R5 collision on inbound
        dw_(3'd2, 32'h00000001);
        exp_h(32'h00000001, "R5 host gets old inbound word");
        cyc(1, 0, 3'd2, 0, 1, 1, 3'd2, 32'h00000077);
        chk("R5 no rx_evt on collision", {31'd0, rx_evt}, 32'd0);
        hr_(3'd3, 32'h1, "R5 inbound ends full");
        hr_(3'd2, 32'h00000077, "R5 inbound new word");

        // R7 inbound flags
        dw_(3'd3, 32'h000000AB);
        hr_(3'd3, 32'hAA, "R7 device flags, bit0 ignored");
        hw_(3'd3, 32'h0);
        dr_(3'd3, 32'hAA, "R7 host write to in ctl ignored");

        // R11 unmapped and peek writes
        hr_(3'd7, 32'h0, "R11 address 7 reads zero");
        hw_(3'd6, 32'h12345678);
        hw_(3'd4, 32'h12345678);
        hr_(3'd4, 32'h33333333, "R11 writes to 6 and peek ignored");
        hr_(3'd1, 32'h54, "R11 out ctl unchanged");
        dr_(3'd6, 32'h0, "R1 address 6 reads zero on device");
        idle();

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule